// File: doc/BRIEF.md
# Stack-Machine ALU Execution Unit

This block is the execution datapath of a stack-oriented processor core. Two registers, the top item and the item beneath it, sit in front of a small register-file stack that holds the deeper items. Each clock with `en` high, the unit takes one decoded operation and carries it out. The operation may be an arithmetic or logic operation on two items, a one-operand transform of the top item, a reordering of the top items, or a literal push. The stack then grows by one, shrinks by one or keeps its depth. Instruction fetch, branching, the return stack and memory access are outside this block.

A two-operand operation comes in two forms, selected by `keep_args`. With `keep_args` low it consumes both operands and leaves the result in their place. With `keep_args` high it keeps both operands and places the result above them, which saves a separate duplicate step. Four status flags (carry, overflow, negative, zero) are kept for a branch unit to test: zero, non-zero, sign, no-sign, no-overflow and no-carry conditions. A stack overrun or underrun is refused and recorded in a sticky error bit instead of wrapping.

All pins are plain control and status pins. An operation is offered by holding `en` high for one clock, and the unit accepts one operation on every such clock. There is no back-pressure: the unit never stalls, and its results show on the outputs after the edge that accepts the operation.

Top module: `stk_alu_core`

## Requirements
- R1: With `keep_args` low, a two-operand operation (opcodes 1 ADD, 2 ADC, 3 SUB, 4 RSUB, 5 AND, 6 OR, 7 XOR) on a stack of depth two or more replaces the top two items with its result, and `depth` falls by one. The second item is the left operand n1 and the top item is the right operand n2.
- R2: With `keep_args` high, a two-operand operation keeps n1 and n2 in place and pushes the result above them, so `nos` shows the old top and `depth` rises by one.
- R3: ADD gives n1+n2; ADC gives n1+n2+C, where C is the current carry flag; SUB gives n1-n2; RSUB gives n2-n1. These four set `flag_c` to the carry out of the adder (for the subtracts this is not-borrow: 1 when no borrow occurs). They set `flag_v` to two's-complement signed overflow.
- R4: AND, OR and XOR give the bitwise function of n1 and n2.
- R5: The one-operand operations replace the top item and leave depth unchanged. They are 8 NOT (bitwise invert), 9 SHL (shift left by one, 0 in), 10 ASR (shift right by one, sign bit kept), 11 LSR (shift right by one, 0 in), 12 ROR (rotate right by one) and 13 ROL (rotate left by one).
- R6: 14 ZEQ replaces the top item with all ones when it was zero and with all zeros otherwise.
- R7: Every operation with code 1 to 14 sets `flag_n` to the result's top bit and `flag_z` to whether the result is zero. Only codes 1 to 4 change `flag_c` and `flag_v`. Stack operations, 21 LIT, 0 NOP and codes 22 to 31 leave all four flags unchanged.
- R8: 15 DUP pushes a copy of the top item; 19 OVER pushes a copy of the second item; 21 LIT pushes `lit`; 17 DROP removes the top item; 20 NIP removes the second item; 18 SWAP exchanges the top two. Items pushed deeper than two are returned intact when the stack drains.
- R9: 16 QDUP pushes a copy of the top item when it is non-zero and leaves the stack as it is when the top item is zero.
- R10: An operation that needs more items than `depth` (two for codes 1 to 7, 18, 19 and 20; one for codes 8 to 17) is refused. So is an operation that would push while `depth` equals RAM_DEPTH+2. A refused operation changes no item, no flag and no depth, and sets `stk_err`. `stk_err` stays set until reset.
- R11: While `en` is low, no output changes, whatever `op`, `keep_args` and `lit` carry.
- R12: After reset, `depth` is 0, `tos`, `nos`, the flags and `stk_err` are 0. At all times `tos` reads 0 when the stack is empty, and `nos` reads 0 when fewer than two items are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Execute the presented operation on this clock |
| op | input | 5 | Decoded operation code |
| keep_args | input | 1 | Two-operand form: 1 keeps operands and pushes, 0 consumes |
| lit | input | W | Value pushed by LIT |
| tos | output | W | Top stack item |
| nos | output | W | Second stack item |
| depth | output | DW | Number of items held (0 to RAM_DEPTH+2) |
| flag_c | output | 1 | Carry / not-borrow |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Negative (result top bit) |
| flag_z | output | 1 | Result was zero |
| stk_err | output | 1 | Sticky stack overrun/underrun |

## Verification
Every result of an accepted operation is due exactly one clock later: `tos`, `nos`, `depth`, the four flags and `stk_err` all come from registers loaded on the accepting edge. The deeper items return through the combinational read of the stack file on a later pop. The bench therefore presents one operation at a falling edge and compares every output at the next falling edge, half a period after the edge that took it. Its reference stack is a plain queue, so a deep item written many operations earlier is checked on the cycle it surfaces into `nos`. Idle clocks are compared the same way, which shows that nothing moves without `en`.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADC  = 5'd2,
    OP_SUB  = 5'd3,
    OP_RSUB = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_NOT  = 5'd8,
    OP_SHL  = 5'd9,
    OP_ASR  = 5'd10,
    OP_LSR  = 5'd11,
    OP_ROR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ZEQ  = 5'd14,
    OP_DUP  = 5'd15,
    OP_QDUP = 5'd16,
    OP_DROP = 5'd17,
    OP_SWAP = 5'd18,
    OP_OVER = 5'd19,
    OP_NIP  = 5'd20,
    OP_LIT  = 5'd21
  } op_e;

endpackage

// File: rtl/stk_alu_calc.sv
// Combinational result and arithmetic-flag generator.
module stk_alu_calc
  import stk_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] n1_i,
  input  logic [W-1:0] n2_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         vout_o
);

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_ci;
  logic [W:0]   add_sum;

  // Adder operand steering: subtracts become x + ~y + 1.
  always_comb begin
    add_x  = n1_i;
    add_y  = n2_i;
    add_ci = 1'b0;
    case (op_i)
      OP_ADC:  add_ci = cin_i;
      OP_SUB:  begin add_y = ~n2_i; add_ci = 1'b1; end
      OP_RSUB: begin add_x = n2_i; add_y = ~n1_i; add_ci = 1'b1; end
      default: ;
    endcase
  end

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
  assign cout_o  = add_sum[W];
  assign vout_o  = (add_x[W-1] == add_y[W-1]) && (add_sum[W-1] != add_x[W-1]);

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_RSUB: res_o = add_sum[W-1:0];
      OP_AND:  res_o = n1_i & n2_i;
      OP_OR:   res_o = n1_i | n2_i;
      OP_XOR:  res_o = n1_i ^ n2_i;
      OP_NOT:  res_o = ~n2_i;
      OP_SHL:  res_o = {n2_i[W-2:0], 1'b0};
      OP_ASR:  res_o = {n2_i[W-1], n2_i[W-1:1]};
      OP_LSR:  res_o = {1'b0, n2_i[W-1:1]};
      OP_ROR:  res_o = {n2_i[0], n2_i[W-1:1]};
      OP_ROL:  res_o = {n2_i[W-2:0], n2_i[W-1]};
      OP_ZEQ:  res_o = {W{n2_i == '0}};
      default: res_o = n2_i;
    endcase
  end

endmodule

// File: rtl/stk_ram.sv
// Register-file stack body: one write port, one combinational read port.
module stk_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/stk_depth.sv
// Depth counter with bounds check and sticky error.
module stk_depth #(
  parameter int MAX = 18,
  parameter int DW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          grow_i,
  input  logic          shrink_i,
  input  logic [1:0]    need_i,
  output logic [DW-1:0] depth_o,
  output logic          ok_o,
  output logic          err_o
);

  assign ok_o = (depth_o >= DW'(need_i)) && !(grow_i && (depth_o == DW'(MAX)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_o <= '0;
      err_o   <= 1'b0;
    end else if (en_i) begin
      if (!ok_o) begin
        err_o <= 1'b1;
      end else if (grow_i) begin
        depth_o <= depth_o + DW'(1);
      end else if (shrink_i) begin
        depth_o <= depth_o - DW'(1);
      end
    end
  end

endmodule

// File: rtl/stk_alu_core.sv
// Stack-machine ALU execution unit (top).
module stk_alu_core
  import stk_alu_pkg::*;
#(
  parameter int W         = 32,
  parameter int RAM_DEPTH = 16,
  localparam int MAX      = RAM_DEPTH + 2,
  localparam int DW       = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [4:0]    op,
  input  logic          keep_args,
  input  logic [W-1:0]  lit,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos,
  output logic [DW-1:0] depth,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_n,
  output logic          flag_z,
  output logic          stk_err
);

  localparam int AW = $clog2(RAM_DEPTH);

  op_e          op_c;
  logic [W-1:0] tos_q, nos_q, tos_d, nos_d, push_val;
  logic [W-1:0] alu_res, ram_rdata, ram_top;
  logic         alu_cout, alu_vout;
  logic [1:0]   need;
  logic         grow, shrink, is_alu, is_arith;
  logic         ok, step, ram_we;
  logic [DW-1:0] dm2, dm3;
  logic         fc_q, fv_q, fn_q, fz_q;

  assign op_c = op_e'(op);

  stk_alu_calc #(.W(W)) u_calc (
    .op_i   (op_c),
    .n1_i   (nos_q),
    .n2_i   (tos_q),
    .cin_i  (fc_q),
    .res_o  (alu_res),
    .cout_o (alu_cout),
    .vout_o (alu_vout)
  );

  stk_depth #(.MAX(MAX), .DW(DW)) u_depth (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .grow_i   (grow),
    .shrink_i (shrink),
    .need_i   (need),
    .depth_o  (depth),
    .ok_o     (ok),
    .err_o    (stk_err)
  );

  assign step   = en && ok;
  assign dm2    = depth - DW'(2);
  assign dm3    = depth - DW'(3);
  assign ram_we = step && grow && (depth >= DW'(2));

  stk_ram #(.W(W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (dm2[AW-1:0]),
    .wdata_i (nos_q),
    .raddr_i (dm3[AW-1:0]),
    .rdata_o (ram_rdata)
  );

  // The item that surfaces into the second slot on a pop.
  assign ram_top = (depth >= DW'(3)) ? ram_rdata : '0;

  // Operation decode: operand need, stack effect and next register values.
  always_comb begin
    need     = 2'd0;
    grow     = 1'b0;
    shrink   = 1'b0;
    is_alu   = 1'b0;
    is_arith = 1'b0;
    push_val = tos_q;
    tos_d    = tos_q;
    nos_d    = nos_q;
    case (op_c)
      OP_ADD, OP_ADC, OP_SUB, OP_RSUB, OP_AND, OP_OR, OP_XOR: begin
        need     = 2'd2;
        is_alu   = 1'b1;
        is_arith = (op_c == OP_ADD) || (op_c == OP_ADC) ||
                   (op_c == OP_SUB) || (op_c == OP_RSUB);
        if (keep_args) begin
          grow     = 1'b1;
          push_val = alu_res;
        end else begin
          shrink = 1'b1;
          tos_d  = alu_res;
          nos_d  = ram_top;
        end
      end
      OP_NOT, OP_SHL, OP_ASR, OP_LSR, OP_ROR, OP_ROL, OP_ZEQ: begin
        need   = 2'd1;
        is_alu = 1'b1;
        tos_d  = alu_res;
      end
      OP_DUP: begin
        need = 2'd1;
        grow = 1'b1;
      end
      OP_QDUP: begin
        need = 2'd1;
        grow = (tos_q != '0);
      end
      OP_DROP: begin
        need   = 2'd1;
        shrink = 1'b1;
        tos_d  = nos_q;
        nos_d  = ram_top;
      end
      OP_SWAP: begin
        need  = 2'd2;
        tos_d = nos_q;
        nos_d = tos_q;
      end
      OP_OVER: begin
        need     = 2'd2;
        grow     = 1'b1;
        push_val = nos_q;
      end
      OP_NIP: begin
        need   = 2'd2;
        shrink = 1'b1;
        nos_d  = ram_top;
      end
      OP_LIT: begin
        grow     = 1'b1;
        push_val = lit;
      end
      default: ;
    endcase
    if (grow) begin
      tos_d = push_val;
      nos_d = tos_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos_q <= '0;
      nos_q <= '0;
      fc_q  <= 1'b0;
      fv_q  <= 1'b0;
      fn_q  <= 1'b0;
      fz_q  <= 1'b0;
    end else if (step) begin
      tos_q <= tos_d;
      nos_q <= nos_d;
      if (is_alu) begin
        fn_q <= alu_res[W-1];
        fz_q <= (alu_res == '0);
        if (is_arith) begin
          fc_q <= alu_cout;
          fv_q <= alu_vout;
        end
      end
    end
  end

  assign tos    = tos_q;
  assign nos    = nos_q;
  assign flag_c = fc_q;
  assign flag_v = fv_q;
  assign flag_n = fn_q;
  assign flag_z = fz_q;

endmodule

// File: rtl/stk_alu_chk.sv
// Property checker bound to the execution unit.
module stk_alu_chk
  import stk_alu_pkg::*;
#(
  parameter int W         = 32,
  parameter int RAM_DEPTH = 16,
  localparam int MAX      = RAM_DEPTH + 2,
  localparam int DW       = $clog2(MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [4:0]    op,
  input logic          keep_args,
  input logic [W-1:0]  tos,
  input logic [W-1:0]  nos,
  input logic [DW-1:0] depth,
  input logic          flag_c,
  input logic          flag_v,
  input logic          flag_n,
  input logic          flag_z,
  input logic          stk_err
);

  logic is_bin;
  assign is_bin = (op >= 5'd1) && (op <= 5'd7);

  p_depth_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(MAX));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  p_underrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_NIP) && (depth < DW'(2)) |=> stk_err && $stable(depth) && $stable(tos));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tos) && $stable(nos) && $stable(depth) &&
            $stable({flag_c, flag_v, flag_n, flag_z, stk_err}));

  p_pop_depth_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en && is_bin && !keep_args && (depth >= DW'(2)) |=> depth == $past(depth) - DW'(1));

  p_push_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && is_bin && keep_args && (depth >= DW'(2)) && (depth != DW'(MAX))
    |=> (nos == $past(tos)) && (depth == $past(depth) + DW'(1)));

  p_zero_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_ZEQ) && (depth != '0) |=> tos == {W{$past(tos) == '0}});

  p_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_DUP) && (depth != '0) && (depth != DW'(MAX))
    |=> (tos == $past(tos)) && (nos == $past(tos)) && (depth == $past(depth) + DW'(1)));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_SWAP) && (depth >= DW'(2)) |=> (tos == $past(nos)) && (nos == $past(tos)));

  p_shuffle_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op >= 5'd15) |=> $stable({flag_c, flag_v, flag_n, flag_z}));

  p_empty_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (tos == '0) && (nos == '0));

endmodule

bind stk_alu_core stk_alu_chk #(.W(W), .RAM_DEPTH(RAM_DEPTH)) u_chk (.*);

// File: tb/stk_alu_core_test.sv
module stk_alu_core_test;

  localparam int W    = 32;
  localparam int RD   = 16;
  localparam int MAXD = RD + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [4:0]    op = '0;
  logic          keep_args = 1'b0;
  logic [W-1:0]  lit = '0;
  logic [W-1:0]  tos, nos;
  logic [4:0]    depth;
  logic          flag_c, flag_v, flag_n, flag_z, stk_err;

  int errors = 0;
  int checks = 0;

  // Reference state
  logic [W-1:0] stk[$];
  logic m_c, m_v, m_n, m_z, m_err;

  always #5 clk = ~clk;

  stk_alu_core #(.W(W), .RAM_DEPTH(RD)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .keep_args(keep_args), .lit(lit),
    .tos(tos), .nos(nos), .depth(depth), .flag_c(flag_c), .flag_v(flag_v),
    .flag_n(flag_n), .flag_z(flag_z), .stk_err(stk_err)
  );

  task automatic check(input string tag);
    int d = stk.size();
    logic [W-1:0] et = (d >= 1) ? stk[d-1] : '0;
    logic [W-1:0] eb = (d >= 2) ? stk[d-2] : '0;
    logic [4:0] ef = {m_c, m_v, m_n, m_z, m_err};
    checks++;
    if (tos !== et || nos !== eb || depth !== d[4:0] ||
        {flag_c, flag_v, flag_n, flag_z, stk_err} !== ef) begin
      errors++;
      $display("FAIL %s: got tos=%h nos=%h depth=%0d cvnz/err=%b expected tos=%h nos=%h depth=%0d cvnz/err=%b",
               tag, tos, nos, depth, {flag_c, flag_v, flag_n, flag_z, stk_err}, et, eb, d, ef);
    end
  endtask

  task automatic do_reset(input string tag);
    en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    stk.delete();
    m_c = 0; m_v = 0; m_n = 0; m_z = 0; m_err = 0;
    check(tag);
  endtask

  // Present one operation, advance the model, compare one clock later.
  task automatic step(input logic [4:0] o, input logic k, input logic [W-1:0] lv, input string tag);
    int d = stk.size();
    logic [W-1:0] t = (d >= 1) ? stk[d-1] : '0;
    logic [W-1:0] s = (d >= 2) ? stk[d-2] : '0;
    logic [W-1:0] r = '0;
    logic [W:0] wide;
    int need = 0;
    bit grow = 0, alu = 0, arith = 0;
    if (o >= 1 && o <= 7) begin need = 2; alu = 1; arith = (o <= 4); grow = k; end
    else if (o >= 8 && o <= 14) begin need = 1; alu = 1; end
    else if (o == 15 || o == 17) need = 1;
    else if (o == 16) begin need = 1; grow = (t != 0); end
    else if (o >= 18 && o <= 20) need = 2;
    if (o == 15 || o == 19 || o == 21) grow = 1;
    if (d < need || (grow && d == MAXD)) begin
      m_err = 1;
    end else begin
      case (o)
        1: begin wide = {1'b0, s} + {1'b0, t}; r = wide[W-1:0]; m_c = wide[W];
                 m_v = (s[W-1] == t[W-1]) && (r[W-1] != s[W-1]); end
        2: begin wide = {1'b0, s} + {1'b0, t} + {{W{1'b0}}, m_c}; r = wide[W-1:0]; m_c = wide[W];
                 m_v = (s[W-1] == t[W-1]) && (r[W-1] != s[W-1]); end
        3: begin r = s - t; m_c = (s >= t); m_v = (s[W-1] != t[W-1]) && (r[W-1] != s[W-1]); end
        4: begin r = t - s; m_c = (t >= s); m_v = (t[W-1] != s[W-1]) && (r[W-1] != t[W-1]); end
        5: r = s & t;
        6: r = s | t;
        7: r = s ^ t;
        8: r = ~t;
        9: r = t << 1;
        10: r = $signed(t) >>> 1;
        11: r = t >> 1;
        12: r = (t >> 1) | (t << (W-1));
        13: r = (t << 1) | (t >> (W-1));
        14: r = (t == 0) ? '1 : '0;
        default: ;
      endcase
      if (alu) begin m_n = r[W-1]; m_z = (r == 0); end
      if (o >= 1 && o <= 7) begin
        if (!k) begin void'(stk.pop_back()); void'(stk.pop_back()); end
        stk.push_back(r);
      end else if (o >= 8 && o <= 14) stk[d-1] = r;
      else case (o)
        15: stk.push_back(t);
        16: if (t != 0) stk.push_back(t);
        17: void'(stk.pop_back());
        18: begin stk[d-1] = s; stk[d-2] = t; end
        19: stk.push_back(s);
        20: stk.delete(d-2);
        21: stk.push_back(lv);
        default: ;
      endcase
    end
    en = 1'b1; op = o; keep_args = k; lit = lv;
    @(negedge clk);
    en = 1'b0; op = 5'($urandom); keep_args = 1'($urandom); lit = $urandom;
    check(tag);
  endtask

  task automatic idle(input string tag);
    en = 1'b0; op = 5'($urandom); keep_args = 1'($urandom); lit = $urandom;
    @(negedge clk);
    check(tag);
  endtask

  function automatic string tag_of(input logic [4:0] o, input logic k);
    if (o >= 1 && o <= 7) return k ? "R2" : "R1";
    if (o >= 8 && o <= 13) return "R5";
    if (o == 14) return "R6";
    if (o == 16) return "R9";
    if (o >= 15) return "R8";
    return "R7";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("R12");
    // Underrun handling and sticky error
    step(5'd17, 0, 0, "R10");
    step(5'd21, 0, 32'h5, "R10");
    step(5'd1, 0, 0, "R10");
    step(5'd20, 1, 0, "R10");
    idle("R10");

    do_reset("R12");
    // Arithmetic with carry and overflow corners
    step(5'd21, 0, 32'h7FFF_FFFF, "R8");
    step(5'd21, 0, 32'h1, "R8");
    step(5'd1, 0, 0, "R3");
    step(5'd21, 0, 32'h8000_0000, "R8");
    step(5'd1, 0, 0, "R3");
    step(5'd21, 0, 32'h7, "R7");
    step(5'd2, 0, 0, "R3");
    step(5'd21, 0, 32'h5, "R8");
    step(5'd21, 0, 32'h7, "R8");
    step(5'd3, 0, 0, "R3");
    step(5'd4, 0, 0, "R3");
    step(5'd21, 0, 32'h8000_0000, "R8");
    step(5'd21, 0, 32'h1, "R8");
    step(5'd3, 1, 0, "R3");
    // Logic in both stack forms
    step(5'd21, 0, 32'h0F0F_F0F0, "R8");
    step(5'd5, 1, 0, "R2");
    step(5'd6, 0, 0, "R1");
    step(5'd7, 1, 0, "R4");
    step(5'd5, 0, 0, "R4");
    // One-operand transforms
    step(5'd21, 0, 32'h8000_0001, "R8");
    step(5'd8, 0, 0, "R5");
    step(5'd8, 0, 0, "R5");
    step(5'd9, 0, 0, "R5");
    step(5'd21, 0, 32'h8000_0001, "R8");
    step(5'd10, 0, 0, "R5");
    step(5'd11, 0, 0, "R5");
    step(5'd12, 0, 0, "R5");
    step(5'd13, 0, 0, "R5");
    step(5'd13, 0, 0, "R5");
    step(5'd14, 0, 0, "R6");
    step(5'd14, 0, 0, "R6");
    step(5'd1, 1, 0, "R7");
    step(5'd9, 0, 0, "R7");
    step(5'd21, 0, 32'h0, "R7");
    step(5'd0, 0, 0, "R7");
    step(5'd25, 1, 0, "R7");
    // Stack shuffles
    step(5'd16, 0, 0, "R9");
    step(5'd21, 0, 32'hA5, "R8");
    step(5'd16, 0, 0, "R9");
    step(5'd15, 0, 0, "R8");
    step(5'd19, 0, 0, "R8");
    step(5'd18, 0, 0, "R8");
    step(5'd20, 0, 0, "R8");
    step(5'd17, 0, 0, "R8");
    idle("R11");
    idle("R11");
    idle("R11");

    do_reset("R12");
    // Fill to the limit, overrun, then drain
    for (int i = 0; i < MAXD; i++) step(5'd21, 0, 32'h100 + i, "R8");
    step(5'd21, 0, 32'hDEAD, "R10");
    step(5'd5, 1, 0, "R10");
    step(5'd15, 0, 0, "R10");
    step(5'd6, 0, 0, "R1");
    for (int i = 0; i < MAXD; i++) step(5'd17, 0, 0, "R8");

    do_reset("R12");
    for (int i = 0; i < 600; i++) begin
      logic [4:0] o = ($urandom_range(0, 3) == 0) ? 5'd21 : 5'($urandom_range(0, 21));
      logic k = 1'($urandom);
      logic [W-1:0] v = ($urandom_range(0, 3) == 0) ? '0 : $urandom;
      if ($urandom_range(0, 7) == 0) idle("R11");
      else step(o, k, v, tag_of(o, k));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule